// File: doc/BRIEF.md
# Legacy and Error Interrupt Controller

This block sits between a link controller and the host interrupt fabric. It watches four level-sensitive legacy INTx lines and six error event lines. For each INTx source it keeps a pending flag, an enable bit and an arm flag. For the error events it keeps a sticky status word and an enable mask. A small register port, with single-cycle writes and combinational reads, lets software see and steer all of this state.

Each INTx source drives its own host line. That line gives a one-cycle pulse when the source is pending, enabled and armed. The pulse disarms the source. Software re-arms it by writing the source index to an end-of-interrupt register. If the input is still high at that point, a new pulse follows.

Error events latch into the raw status word whatever the enable mask holds. The masked view is raw ANDed with the mask, and it drives one error line plus a fatal-class line. Software clears status bits by writing ones.

Top module: `intx_err_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every INTx pending flag, the raw error status and all interrupt outputs are 0, and every INTx source is armed.
- R2: Bit 0 of the INTx status register at 0x184 + 0x10·i reads the level of INTx input i as sampled one clock earlier, whatever the enable setting. Writes to these status registers have no effect.
- R3: Writing a word with bit 0 set to 0x188 + 0x10·i sets enable i, and writing it to 0x18C + 0x10·i clears enable i. A write with bit 0 at 0 does nothing. A read of either address returns enable i in bit 0.
- R4: INTx host line i goes high for exactly one cycle on the clock edge after the source is pending, enabled and armed. A disabled source never drives its line.
- R5: After a pulse, source i gives no further pulse until a write of the value i to the end-of-interrupt register at 0x050. An end-of-interrupt that carries another index, or an index of 4 or more, leaves the source disarmed. If the input is still high at the end-of-interrupt, the line pulses again on the following edge.
- R6: The raw error register at 0x1C0 latches events whatever the enable mask holds, and the bits stay set after the event goes away. The bit order is 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 fatal tag-lookup, 5 end-to-end CRC.
- R7: A write to the error enable-set register at 0x1C8 ORs its low six bits into the mask. A write to the enable-clear register at 0x1CC removes them. Both addresses read back the mask. The masked status at 0x1C4 reads raw AND mask.
- R8: Writing ones to 0x1C0 or 0x1C4 clears those raw bits, and zero bits have no effect. An event that arrives in the same cycle as its clear stays set.
- R9: err_irq_o is the OR of the masked status bits. err_fatal_o is high when masked bit 1 or masked bit 4 is set.
- R10: A read of an address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| intx_i | input | 4 | Legacy INTx level inputs |
| err_ev_i | input | 6 | Error event inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| intx_irq_o | output | 4 | Per-source INTx host interrupt pulses |
| err_irq_o | output | 1 | Error interrupt, OR of masked status |
| err_fatal_o | output | 1 | Fatal-class masked error present |

## Verification
The bench holds an INTx input high across a pulse and checks the line. A design that re-fired without an end-of-interrupt would pulse again. A design that ignored the index would re-arm on an end-of-interrupt meant for a different or out-of-range index. It sets an enable while the input is already high, so a design that only fired on an input edge would stay silent. On the error side, it raises a clear and an event for the same bit in the same cycle. A design that let the clear win would lose the event. It also latches events while they are masked, so a design that gated the raw register with the mask would read zero. It writes zero bits to the status and enable-clear registers, which a sloppy write decoder would act on.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned ERR_W       = 6;
  localparam int unsigned INTX_BASE   = 32'h184;
  localparam int unsigned INTX_STRIDE = 32'h010;
  localparam int unsigned OFS_ESET    = 4;
  localparam int unsigned OFS_ECLR    = 8;
  localparam int unsigned EOI_ADDR    = 32'h050;
  localparam int unsigned ERR_RAW     = 32'h1C0;
  localparam int unsigned ERR_MSK     = 32'h1C4;
  localparam int unsigned ERR_SET     = 32'h1C8;
  localparam int unsigned ERR_CLR     = 32'h1CC;
  // fatal class: bit 1 (fatal) and bit 4 (tag lookup)
  localparam logic [ERR_W-1:0] ERR_FATAL_MASK = 6'b01_0010;
endpackage

// File: rtl/irq_intx_chan.sv
module irq_intx_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic eoi_i,
  output logic pend_o,
  output logic en_o,
  output logic irq_o
);
  logic pend_q, en_q, armed_q, irq_q;
  logic fire;

  assign fire = pend_q & en_q & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      pend_q <= level_i;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      // a pulse disarms; EOI only matters once disarmed
      if (fire)       armed_q <= 1'b0;
      else if (eoi_i) armed_q <= 1'b1;
      irq_q <= fire;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R4
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(en_q));
  // R5
  irq_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> !armed_q);
  // R5
  rearm_by_eoi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(eoi_i));
endmodule

// File: rtl/irq_err_bank.sv
module irq_err_bank
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] ev_i,
  input  logic [ERR_W-1:0] en_set_i,
  input  logic [ERR_W-1:0] en_clr_i,
  input  logic [ERR_W-1:0] clr_i,
  output logic [ERR_W-1:0] raw_o,
  output logic [ERR_W-1:0] en_o,
  output logic [ERR_W-1:0] masked_o
);
  logic [ERR_W-1:0] raw_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | ev_i;  // new event beats clear
      en_q  <= (en_q & ~en_clr_i) | en_set_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = raw_q & en_q;

  // R6
  raw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_q & ($past(raw_q) & ~$past(clr_i))) == ($past(raw_q) & ~$past(clr_i))));
  // R8
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((raw_q & $past(ev_i)) == $past(ev_i)));
endmodule

// File: rtl/intx_err_irq_ctrl.sv
module intx_err_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_INTX = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_INTX-1:0] intx_i,
  input  logic [ERR_W-1:0]  err_ev_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_INTX-1:0] intx_irq_o,
  output logic              err_irq_o,
  output logic              err_fatal_o
);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(EOI_ADDR);
  localparam logic [ADDR_W-1:0] A_ERAW = ADDR_W'(ERR_RAW);
  localparam logic [ADDR_W-1:0] A_EMSK = ADDR_W'(ERR_MSK);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(ERR_SET);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(ERR_CLR);

  function automatic logic [ADDR_W-1:0] intx_addr(int unsigned idx, int unsigned ofs);
    return ADDR_W'(INTX_BASE + idx * INTX_STRIDE + ofs);
  endfunction

  logic [N_INTX-1:0] ch_set, ch_clr, ch_eoi, ch_pend, ch_en;
  logic [ERR_W-1:0]  e_set, e_clr, e_wclr, e_raw, e_en, e_msk;

  always_comb begin
    for (int i = 0; i < N_INTX; i++) begin
      ch_set[i] = reg_we_i && reg_addr_i == intx_addr(i, OFS_ESET) && reg_wdata_i[0];
      ch_clr[i] = reg_we_i && reg_addr_i == intx_addr(i, OFS_ECLR) && reg_wdata_i[0];
      ch_eoi[i] = reg_we_i && reg_addr_i == A_EOI && reg_wdata_i == DATA_W'(i);
    end
    e_set  = (reg_we_i && reg_addr_i == A_ESET) ? reg_wdata_i[ERR_W-1:0] : '0;
    e_clr  = (reg_we_i && reg_addr_i == A_ECLR) ? reg_wdata_i[ERR_W-1:0] : '0;
    e_wclr = (reg_we_i && (reg_addr_i == A_ERAW || reg_addr_i == A_EMSK))
             ? reg_wdata_i[ERR_W-1:0] : '0;
  end

  for (genvar g = 0; g < N_INTX; g++) begin : g_chan
    irq_intx_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (intx_i[g]),
      .en_set_i (ch_set[g]),
      .en_clr_i (ch_clr[g]),
      .eoi_i    (ch_eoi[g]),
      .pend_o   (ch_pend[g]),
      .en_o     (ch_en[g]),
      .irq_o    (intx_irq_o[g])
    );
  end

  irq_err_bank u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (err_ev_i),
    .en_set_i (e_set),
    .en_clr_i (e_clr),
    .clr_i    (e_wclr),
    .raw_o    (e_raw),
    .en_o     (e_en),
    .masked_o (e_msk)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_INTX; i++) begin
      if (reg_addr_i == intx_addr(i, 0)) reg_rdata_o[0] = ch_pend[i];
      if (reg_addr_i == intx_addr(i, OFS_ESET) || reg_addr_i == intx_addr(i, OFS_ECLR))
        reg_rdata_o[0] = ch_en[i];
    end
    if (reg_addr_i == A_ERAW) reg_rdata_o[ERR_W-1:0] = e_raw;
    if (reg_addr_i == A_EMSK) reg_rdata_o[ERR_W-1:0] = e_msk;
    if (reg_addr_i == A_ESET || reg_addr_i == A_ECLR) reg_rdata_o[ERR_W-1:0] = e_en;
  end

  assign err_irq_o   = |e_msk;
  assign err_fatal_o = |(e_msk & ERR_FATAL_MASK);

  // R9
  fatal_is_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_fatal_o |-> (e_raw != '0));
endmodule

// File: tb/intx_err_irq_ctrl_bench.sv
module intx_err_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx = '0;
  logic [5:0]  ev = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        eirq, efat;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intx_err_irq_ctrl u_intx_err_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .intx_i(intx), .err_ev_i(ev),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .intx_irq_o(irq), .err_irq_o(eirq), .err_fatal_o(efat)
  );

  typedef struct packed {
    logic        w;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [7:0]  req;
  } op_t;

  // register walk: R1 R3 R7 R10
  localparam op_t OPS [16] = '{
    '{1'b0, 12'h188, 32'h0, 32'h00, 8'd1},
    '{1'b1, 12'h188, 32'h1, 32'h00, 8'd3},
    '{1'b0, 12'h18C, 32'h0, 32'h01, 8'd3},
    '{1'b0, 12'h198, 32'h0, 32'h00, 8'd3},
    '{1'b1, 12'h18C, 32'h2, 32'h00, 8'd3},
    '{1'b0, 12'h188, 32'h0, 32'h01, 8'd3},
    '{1'b1, 12'h18C, 32'h1, 32'h00, 8'd3},
    '{1'b0, 12'h188, 32'h0, 32'h00, 8'd3},
    '{1'b1, 12'h1C8, 32'h3F, 32'h00, 8'd7},
    '{1'b0, 12'h1CC, 32'h0, 32'h3F, 8'd7},
    '{1'b1, 12'h1CC, 32'h05, 32'h00, 8'd7},
    '{1'b0, 12'h1C8, 32'h0, 32'h3A, 8'd7},
    '{1'b0, 12'h1C4, 32'h0, 32'h00, 8'd7},
    '{1'b0, 12'h300, 32'h0, 32'h00, 8'd10},
    '{1'b1, 12'h184, 32'h1, 32'h00, 8'd2},
    '{1'b0, 12'h184, 32'h0, 32'h00, 8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = a; #1 d = rdata;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 intx lines", {28'h0, irq}, 32'h0);
    chk("R1 error lines", {30'h0, eirq, efat}, 32'h0);
    rd(12'h1C0, v); chk("R1 raw error", v, 32'h0);

    foreach (OPS[i]) begin
      if (OPS[i].w) wr(OPS[i].a, OPS[i].d);
      else begin
        rd(OPS[i].a, v);
        chk($sformatf("R%0d table[%0d]", OPS[i].req, i), v, OPS[i].exp);
      end
    end

    // R2 / R4: disabled source 2 pends but never fires
    @(negedge clk); intx[2] = 1'b1;
    step(2);
    chk("R4 disabled no pulse", {28'h0, irq}, 32'h0);
    rd(12'h1A4, v); chk("R2 pending src2", v, 32'h1);

    // R4: enabled source 0
    wr(12'h188, 32'h1);
    intx[0] = 1'b1;
    @(negedge clk); chk("R4 not yet", {28'h0, irq}, 32'h0);
    @(negedge clk); chk("R4 pulse src0", {28'h0, irq}, 32'h1);
    @(negedge clk); chk("R4 one cycle", {28'h0, irq}, 32'h0);
    step(3); chk("R5 no refire", {28'h0, irq}, 32'h0);

    // R5: wrong and out-of-range indices
    wr(12'h050, 32'h1); step(2); chk("R5 other index", {28'h0, irq}, 32'h0);
    wr(12'h050, 32'h7); step(2); chk("R5 bad index", {28'h0, irq}, 32'h0);
    wr(12'h050, 32'h0);
    chk("R5 eoi edge", {28'h0, irq}, 32'h0);
    @(negedge clk); chk("R5 refire held input", {28'h0, irq}, 32'h1);
    @(negedge clk); chk("R5 refire one cycle", {28'h0, irq}, 32'h0);

    // R5: eoi while input low, then new assertion fires
    intx[0] = 1'b0; step(2);
    wr(12'h050, 32'h0); step(3);
    chk("R5 eoi low input", {28'h0, irq}, 32'h0);
    intx[0] = 1'b1;
    step(2); chk("R5 rearmed pulse", {28'h0, irq}, 32'h1);

    // R4: enabling an already-pending source fires
    wr(12'h1A8, 32'h1);
    chk("R4 enable edge", {28'h0, irq}, 32'h0);
    @(negedge clk); chk("R4 late enable pulse", {28'h0, irq}, 32'h4);

    // R6 R7 R9: mask is 0x3A
    @(negedge clk); ev = 6'h01; @(negedge clk); ev = 6'h00;
    rd(12'h1C0, v); chk("R6 masked event latched", v, 32'h01);
    rd(12'h1C4, v); chk("R7 masked view", v, 32'h00);
    chk("R9 no err irq", {31'h0, eirq}, 32'h0);
    @(negedge clk); ev = 6'h08; @(negedge clk); ev = 6'h00;
    rd(12'h1C0, v); chk("R6 sticky raw", v, 32'h09);
    chk("R9 err irq", {30'h0, eirq, efat}, 32'h2);
    @(negedge clk); ev = 6'h10; @(negedge clk); ev = 6'h00;
    rd(12'h1C4, v); chk("R7 masked 18", v, 32'h18);
    chk("R9 fatal", {30'h0, eirq, efat}, 32'h3);

    // R8
    wr(12'h1C4, 32'h10);
    rd(12'h1C0, v); chk("R8 w1c masked addr", v, 32'h09);
    chk("R9 fatal cleared", {31'h0, efat}, 32'h0);
    wr(12'h1C0, 32'h0);
    rd(12'h1C0, v); chk("R8 zero write", v, 32'h09);
    @(negedge clk); we = 1'b1; addr = 12'h1C0; wdata = 32'h2; ev = 6'h02;
    @(negedge clk); we = 1'b0; ev = 6'h00;
    rd(12'h1C0, v); chk("R8 event beats clear", v, 32'h0B);
    chk("R9 fatal bit1", {31'h0, efat}, 32'h1);
    wr(12'h1C0, 32'h3F);
    rd(12'h1C0, v); chk("R8 full clear", v, 32'h00);
    chk("R9 idle", {30'h0, eirq, efat}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule